// File: doc/BRIEF.md
# Flash Controller Configuration and Protection Register Block

This block holds two byte-wide registers of an embedded flash controller and enforces how software may change them. The configuration register carries two interrupt enables and a switch that puts the controller into security-key access mode. In that mode, writes to the flash array are taken as backdoor key words and array reads return invalid data. Otherwise an array write starts a command write sequence. The key switch may change only while the security logic reports that key entry is enabled.

The protection register describes a protected region at the high end and one at the low end of the array. It also has a global open bit. The open bit and the two region disable bits can only be cleared. Each region's size field may be rewritten only while its disable bit is still set. Once software clears a disable bit, the matching size is frozen until the next reset. The protection value after reset comes from an input port, which stands in for a value loaded from nonvolatile memory. A registered interrupt request is raised from the controller's command-buffer-empty and command-complete flags, each gated by its enable.

Top module: `fcp_regblock`

## Requirements
- R1: Reading offset 3 returns {buffer-empty interrupt enable (bit 7), command-complete interrupt enable (bit 6), key-access bit (bit 5), 5'b0}. The two enables take bits 7 and 6 of any write to offset 3. Bits 4..0 always read 0.
- R2: After reset, offset 3 reads 0x00, `irq_req` is 0 and `key_access_mode` is 0.
- R3: A write to offset 3 loads bit 5 into the key-access bit only while `key_en_status` is 1. Otherwise the bit keeps its value.
- R4: `irq_req` is 1 in the cycle after an edge at which (`buf_empty_flag` and bit 7 of offset 3) or (`cmd_done_flag` and bit 6 of offset 3) held. It is 0 in the cycle after an edge at which neither held.
- R5: After reset, offset 4 reads `prot_reset_val`. The layout is open (bit 7), nonvolatile spare (bit 6), high disable (bit 5), high size (bits 4:3), low disable (bit 2) and low size (bits 1:0).
- R6: The open bit can only go from 1 to 0. Writing 1 while it is 0 leaves it at 0.
- R7: The high size takes bits 4:3 of a write to offset 4 only if the high disable bit was 1 before that write. A single write may both clear the disable and load the size.
- R8: The low size takes bits 1:0 of a write to offset 4 only if the low disable bit was 1 before that write. Otherwise it holds.
- R9: The high and low disable bits can only be cleared. A written 1 never sets them again.
- R10: Bit 6 of offset 4 keeps its reset value and ignores writes.
- R11: Reads of offsets other than 3 and 4 return 0. Writes there change no register.
- R12: `key_access_mode`, `prot_open`, `high_dis`, `high_size`, `low_dis` and `low_size` always equal the corresponding register fields.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Register offset |
| bus_we | input | 1 | Write strobe, one byte per cycle |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr`, combinational |
| buf_empty_flag | input | 1 | Command buffer empty flag from the controller |
| cmd_done_flag | input | 1 | All commands complete flag from the controller |
| key_en_status | input | 1 | Security logic reports key entry enabled |
| prot_reset_val | input | 8 | Protection image taken while in reset |
| irq_req | output | 1 | Registered interrupt request |
| key_access_mode | output | 1 | Array accesses are key words when 1 |
| prot_open | output | 1 | Global protection open bit |
| high_dis | output | 1 | High region protection disabled |
| high_size | output | 2 | High region size code |
| low_dis | output | 1 | Low region protection disabled |
| low_size | output | 2 | Low region size code |

## Verification
The key overlap is one write to offset 4 that clears a disable bit and supplies a new size for the same region. The size gate must use the disable value from before that edge, so the bench sends such a write for the high region and expects the new size to land. It then sends a second write, which must leave both the size and the disable untouched. A second overlap is an enable write in the same cycle that a flag is already asserted. The bench samples `irq_req` at the next two falling edges and expects the old gated value first, then the new one.

// File: rtl/fcp_pkg.sv
package fcp_pkg;

   localparam int REG_W = 8;

   typedef enum logic [0:0] {
      LK_GATED      = 1'b0,
      LK_CLEAR_ONLY = 1'b1
   } lock_mode_e;

   typedef struct packed {
      logic       buf_ie;
      logic       done_ie;
      logic       key_acc;
      logic [4:0] zero;
   } cfg_t;

   typedef struct packed {
      logic       open;
      logic       nv;
      logic       hdis;
      logic [1:0] hsize;
      logic       ldis;
      logic [1:0] lsize;
   } prot_t;

endpackage

// File: rtl/fcp_lock_field.sv
module fcp_lock_field #(
   parameter int                  W    = 1,
   parameter fcp_pkg::lock_mode_e MODE = fcp_pkg::LK_GATED
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] rst_val,
   input  logic         wr_en,
   input  logic [W-1:0] wr_val,
   input  logic         gate,
   output logic [W-1:0] q
);

   if (W < 1) begin : g_bad_w
      $error("fcp_lock_field: W must be at least 1");
   end

   if (MODE == fcp_pkg::LK_CLEAR_ONLY) begin : g_clr
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)             q <= rst_val;
         else if (wr_en && gate) q <= q & wr_val;
      end

      // R6, R9: no bit of a clear-only field ever rises outside reset
      p_clear_only_r9: assert property (@(posedge clk) disable iff (!rst_n)
         (q & ~$past(q)) == '0)
         else $error("clear-only field set a bit");
   end else begin : g_gate
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)             q <= rst_val;
         else if (wr_en && gate) q <= wr_val;
      end

      // R7 (also R3, R8): a closed gate freezes the field
      p_gated_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
         !$past(gate) |-> $stable(q))
         else $error("gated field changed while gate was closed");
   end

endmodule

// File: rtl/fcp_cfg_reg.sv
module fcp_cfg_reg (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_en,
   input  logic [2:0]    wr_hi,
   input  logic          key_en,
   output fcp_pkg::cfg_t cfg
);

   logic [1:0] ie_q;
   logic       key_q;

   fcp_lock_field #(.W(2), .MODE(fcp_pkg::LK_GATED)) u_ie (
      .clk(clk), .rst_n(rst_n), .rst_val(2'b00),
      .wr_en(wr_en), .wr_val(wr_hi[2:1]), .gate(1'b1), .q(ie_q)
   );

   fcp_lock_field #(.W(1), .MODE(fcp_pkg::LK_GATED)) u_key (
      .clk(clk), .rst_n(rst_n), .rst_val(1'b0),
      .wr_en(wr_en), .wr_val(wr_hi[0]), .gate(key_en), .q(key_q)
   );

   always_comb begin
      cfg.buf_ie  = ie_q[1];
      cfg.done_ie = ie_q[0];
      cfg.key_acc = key_q;
      cfg.zero    = '0;
   end

   // R3: key bit never changes when key entry was reported disabled
   p_key_locked_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(key_en) |-> $stable(key_q))
      else $error("key access bit moved without key enable");

endmodule

// File: rtl/fcp_prot_reg.sv
module fcp_prot_reg (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           wr_en,
   input  logic [6:0]     wr_bits,
   input  logic [7:0]     rst_image,
   output fcp_pkg::prot_t prot
);

   logic       open_q, hdis_q, ldis_q, nv_q;
   logic [1:0] hsize_q, lsize_q;

   fcp_lock_field #(.W(1), .MODE(fcp_pkg::LK_CLEAR_ONLY)) u_open (
      .clk(clk), .rst_n(rst_n), .rst_val(rst_image[7]),
      .wr_en(wr_en), .wr_val(wr_bits[6]), .gate(1'b1), .q(open_q)
   );

   fcp_lock_field #(.W(1), .MODE(fcp_pkg::LK_CLEAR_ONLY)) u_hdis (
      .clk(clk), .rst_n(rst_n), .rst_val(rst_image[5]),
      .wr_en(wr_en), .wr_val(wr_bits[5]), .gate(1'b1), .q(hdis_q)
   );

   fcp_lock_field #(.W(2), .MODE(fcp_pkg::LK_GATED)) u_hsize (
      .clk(clk), .rst_n(rst_n), .rst_val(rst_image[4:3]),
      .wr_en(wr_en), .wr_val(wr_bits[4:3]), .gate(hdis_q), .q(hsize_q)
   );

   fcp_lock_field #(.W(1), .MODE(fcp_pkg::LK_CLEAR_ONLY)) u_ldis (
      .clk(clk), .rst_n(rst_n), .rst_val(rst_image[2]),
      .wr_en(wr_en), .wr_val(wr_bits[2]), .gate(1'b1), .q(ldis_q)
   );

   fcp_lock_field #(.W(2), .MODE(fcp_pkg::LK_GATED)) u_lsize (
      .clk(clk), .rst_n(rst_n), .rst_val(rst_image[1:0]),
      .wr_en(wr_en), .wr_val(wr_bits[1:0]), .gate(ldis_q), .q(lsize_q)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) nv_q <= rst_image[6];
   end

   always_comb begin
      prot.open  = open_q;
      prot.nv    = nv_q;
      prot.hdis  = hdis_q;
      prot.hsize = hsize_q;
      prot.ldis  = ldis_q;
      prot.lsize = lsize_q;
   end

   // R10: spare bit holds its reset value
   p_nv_fixed_r10: assert property (@(posedge clk) disable iff (!rst_n)
      $stable(nv_q))
      else $error("spare bit changed");

   // R8: low size frozen once its disable was clear
   p_lsize_frozen_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(ldis_q) |-> $stable(lsize_q))
      else $error("low size moved while locked");

endmodule

// File: rtl/fcp_irq_gen.sv
module fcp_irq_gen #(
   parameter bit REGISTERED = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic flag_a,
   input  logic en_a,
   input  logic flag_b,
   input  logic en_b,
   output logic irq
);

   logic want;
   assign want = (flag_a & en_a) | (flag_b & en_b);

   if (REGISTERED) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) irq <= 1'b0;
         else        irq <= want;
      end

      // R4: request follows gated flags one cycle later
      p_irq_latency_r4: assert property (@(posedge clk) disable iff (!rst_n)
         irq == $past((flag_a && en_a) || (flag_b && en_b)))
         else $error("interrupt request latency wrong");
   end else begin : g_comb
      assign irq = want;
      logic unused_clk;
      assign unused_clk = clk ^ rst_n;
   end

endmodule

// File: rtl/fcp_regblock.sv
module fcp_regblock #(
   parameter int ADDR_W         = 4,
   parameter int CFG_OFS        = 3,
   parameter int PROT_OFS       = 4,
   parameter bit IRQ_REGISTERED = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_we,
   input  logic [7:0]        bus_wdata,
   output logic [7:0]        bus_rdata,
   input  logic              buf_empty_flag,
   input  logic              cmd_done_flag,
   input  logic              key_en_status,
   input  logic [7:0]        prot_reset_val,
   output logic              irq_req,
   output logic              key_access_mode,
   output logic              prot_open,
   output logic              high_dis,
   output logic [1:0]        high_size,
   output logic              low_dis,
   output logic [1:0]        low_size
);

   localparam int                MAX_OFS = (1 << ADDR_W) - 1;
   localparam logic [ADDR_W-1:0] A_CFG   = ADDR_W'(CFG_OFS);
   localparam logic [ADDR_W-1:0] A_PROT  = ADDR_W'(PROT_OFS);

   if (CFG_OFS == PROT_OFS) begin : g_bad_map
      $error("fcp_regblock: register offsets collide");
   end
   if (CFG_OFS > MAX_OFS || PROT_OFS > MAX_OFS) begin : g_bad_addr
      $error("fcp_regblock: ADDR_W too narrow for offsets");
   end
   if (fcp_pkg::REG_W != 8) begin : g_bad_w
      $error("fcp_regblock: register width must be 8");
   end

   fcp_pkg::cfg_t  cfg;
   fcp_pkg::prot_t prot;
   logic           hit_cfg, hit_prot;

   assign hit_cfg  = (bus_addr == A_CFG);
   assign hit_prot = (bus_addr == A_PROT);

   fcp_cfg_reg u_cfg (
      .clk(clk), .rst_n(rst_n),
      .wr_en(bus_we && hit_cfg), .wr_hi(bus_wdata[7:5]),
      .key_en(key_en_status), .cfg(cfg)
   );

   fcp_prot_reg u_prot (
      .clk(clk), .rst_n(rst_n),
      .wr_en(bus_we && hit_prot),
      .wr_bits({bus_wdata[7], bus_wdata[5:0]}),
      .rst_image(prot_reset_val), .prot(prot)
   );

   fcp_irq_gen #(.REGISTERED(IRQ_REGISTERED)) u_irq (
      .clk(clk), .rst_n(rst_n),
      .flag_a(buf_empty_flag), .en_a(cfg.buf_ie),
      .flag_b(cmd_done_flag),  .en_b(cfg.done_ie),
      .irq(irq_req)
   );

   always_comb begin
      if (hit_cfg)       bus_rdata = cfg;
      else if (hit_prot) bus_rdata = prot;
      else               bus_rdata = '0;
   end

   assign key_access_mode = cfg.key_acc;
   assign prot_open       = prot.open;
   assign high_dis        = prot.hdis;
   assign high_size       = prot.hsize;
   assign low_dis         = prot.ldis;
   assign low_size        = prot.lsize;

   // R1: reserved configuration bits read zero
   p_cfg_low_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
      hit_cfg |-> (bus_rdata[4:0] == 5'b0))
      else $error("reserved configuration bits nonzero");

   // R11: unmapped offsets read zero
   p_unmapped_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (!hit_cfg && !hit_prot) |-> (bus_rdata == 8'h00))
      else $error("unmapped read nonzero");

   // R6: open bit, seen at the port, never rises
   p_open_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(prot_open) |-> !prot_open)
      else $error("open bit set again");

endmodule

// File: tb/fcp_regblock_tb.sv
module fcp_regblock_tb;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [3:0] bus_addr = '0;
   logic       bus_we = 1'b0;
   logic [7:0] bus_wdata = '0;
   logic [7:0] bus_rdata;
   logic       buf_empty_flag = 1'b0;
   logic       cmd_done_flag = 1'b0;
   logic       key_en_status = 1'b0;
   logic [7:0] prot_reset_val = 8'hED;
   logic       irq_req, key_access_mode, prot_open, high_dis, low_dis;
   logic [1:0] high_size, low_size;

   int  checks = 0;
   int  errors = 0;
   bit  done = 1'b0;

   always #2.5 clk = ~clk;

   fcp_regblock u_dut (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .buf_empty_flag(buf_empty_flag), .cmd_done_flag(cmd_done_flag),
      .key_en_status(key_en_status), .prot_reset_val(prot_reset_val),
      .irq_req(irq_req), .key_access_mode(key_access_mode),
      .prot_open(prot_open), .high_dis(high_dis), .high_size(high_size),
      .low_dis(low_dis), .low_size(low_size)
   );

   // scoreboard item: kind 0 = read data, 1 = irq, 2 = key mode, 3 = protection pins
   typedef struct {
      int       kind;
      logic [7:0] exp;
      string    tag;
   } item_t;

   item_t sb_q[$];
   event  mon_ev;

   task automatic push(input int kind, input logic [7:0] exp, input string tag);
      item_t it;
      it.kind = kind;
      it.exp  = exp;
      it.tag  = tag;
      #1;
      sb_q.push_back(it);
      -> mon_ev;
      #0.1;
   endtask

   task automatic rd(input logic [3:0] a, input logic [7:0] exp, input string tag);
      @(negedge clk);
      bus_addr = a;
      bus_we   = 1'b0;
      push(0, exp, tag);
   endtask

   task automatic wr(input logic [3:0] a, input logic [7:0] d);
      @(negedge clk);
      bus_addr  = a;
      bus_wdata = d;
      bus_we    = 1'b1;
      @(negedge clk);
      bus_we    = 1'b0;
   endtask

   initial begin : monitor
      forever begin
         @(mon_ev);
         while (sb_q.size() > 0) begin
            item_t      it;
            logic [7:0] act;
            it = sb_q.pop_front();
            case (it.kind)
               0:       act = bus_rdata;
               1:       act = {7'b0, irq_req};
               2:       act = {7'b0, key_access_mode};
               default: act = {1'b0, prot_open, high_dis, high_size, low_dis, low_size};
            endcase
            checks++;
            if (act !== it.exp) begin
               errors++;
               $display("FAIL %s: actual=%h expected=%h", it.tag, act, it.exp);
            end
         end
      end
   end

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual=timeout expected=finish");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin : driver
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // reset state
      rd(4'd3, 8'h00, "R2 cfg after reset");
      push(1, 8'h00, "R2 irq after reset");
      push(2, 8'h00, "R2 key mode after reset");
      rd(4'd4, 8'hED, "R5 prot after reset");
      push(3, 8'h6D, "R12 prot pins after reset");
      rd(4'd0, 8'h00, "R11 unmapped read");

      // configuration access rules
      wr(4'd3, 8'hFF);
      rd(4'd3, 8'hC0, "R1 R3 cfg write key disabled");
      key_en_status = 1'b1;
      wr(4'd3, 8'h3F);
      rd(4'd3, 8'h20, "R1 R3 cfg write key enabled");
      push(2, 8'h01, "R12 key mode output");
      key_en_status = 1'b0;
      wr(4'd3, 8'h00);
      rd(4'd3, 8'h20, "R3 key bit held");

      // interrupt: enable written while flag already set
      buf_empty_flag = 1'b1;
      wr(4'd3, 8'h80);
      push(1, 8'h00, "R4 irq one cycle after enable");
      @(negedge clk);
      push(1, 8'h01, "R4 irq from buffer empty");
      buf_empty_flag = 1'b0;
      push(1, 8'h01, "R4 irq before flag drop registers");
      @(negedge clk);
      push(1, 8'h00, "R4 irq after flag drop");
      buf_empty_flag = 1'b1;
      cmd_done_flag  = 1'b1;
      wr(4'd3, 8'h40);
      @(negedge clk);
      push(1, 8'h01, "R4 irq from command complete");
      cmd_done_flag = 1'b0;
      @(negedge clk);
      @(negedge clk);
      push(1, 8'h00, "R4 irq gated off with enable clear");
      buf_empty_flag = 1'b0;

      // protection rules
      wr(4'd4, 8'hFF);
      rd(4'd4, 8'hFF, "R7 R8 sizes while unlocked");
      wr(4'd4, 8'h6D);
      rd(4'd4, 8'h6D, "R6 open cleared");
      wr(4'd4, 8'hFF);
      rd(4'd4, 8'h7F, "R6 open stays clear");
      wr(4'd4, 8'h3F);
      rd(4'd4, 8'h7F, "R10 spare bit ignores write");
      wr(4'd4, 8'h4F);
      rd(4'd4, 8'h4F, "R7 disable clear and size load same write");
      wr(4'd4, 8'h3A);
      rd(4'd4, 8'h4A, "R9 R7 high locked low size last load");
      wr(4'd4, 8'hFF);
      rd(4'd4, 8'h4A, "R8 R9 low locked");
      push(3, 8'h0A, "R12 prot pins after locks");

      // unmapped write
      wr(4'd5, 8'hFF);
      rd(4'd5, 8'h00, "R11 unmapped write read back");
      rd(4'd3, 8'h60, "R11 cfg unchanged by unmapped write");
      rd(4'd4, 8'h4A, "R11 prot unchanged by unmapped write");

      @(negedge clk);
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule